// File: doc/BRIEF.md
# Burst-of-Two Double-Rate Memory Core

This block is a synchronous memory with a double-rate data path, modelled as two beat lanes per clock. Lane 0 carries the first beat, which is the low half of a word. Lane 1 carries the second beat, which is the high half. Every access moves one full storage word, twice the lane width. Each address therefore selects a pair of beats, and the address is one bit narrower than a per-beat address would be.

A write command carries the address. Its two beats arrive on the cycle after the command. The beats are merged into one wide word and stored in a single array write. A read command fetches one wide word and returns both halves together on the read lanes, with a single valid flag.

The delay from a read command to its data is either two or three cycles, chosen by a select pin. Reads are coherent with writes. A read issued while a write's data is still on its way into the array returns that write's data.

The block has no valid/ready handshake and accepts no back-pressure. It takes one command per cycle. Read results appear at a fixed latency, and the consumer must accept them in that cycle.

Top module: `sram_b2_core`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `rvalid` is 0 and both read lanes are all zeros.
- R2: A write is `cmd` = 2'b10 with `addr`. On the next cycle, `wbeat0` and `wbeat1` are stored together as one word: `wbeat0` is the low half and `wbeat1` the high half.
- R3: A read is `cmd` = 2'b01 with `addr`. It returns the stored word in one cycle: `rbeat0` carries the low half and `rbeat1` the high half.
- R4: If a read is issued with an effective latency of two, `rvalid` and its data are present in the second cycle after the command's clock edge.
- R5: If a read is issued with an effective latency of three, `rvalid` and its data are present in the third cycle after the command's clock edge.
- R6: Each read command produces exactly one `rvalid` cycle. Reads on consecutive cycles produce `rvalid` on consecutive cycles. `rvalid` never rises without a read.
- R7: A read returns the newest data written to its address. This holds even when the write was issued in the cycle just before and its beats are arriving in the same cycle as the read.
- R8: `lat3` (1 = three cycles, 0 = two) is taken only when no read is in flight. A change made while reads are in flight takes effect for the first read issued after they drain.
- R9: Commands 2'b00 and 2'b11 do nothing. Write-beat inputs on any cycle that does not follow a write command change no stored word.
- R10: In every cycle where `rvalid` is 0, both read lanes are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | 00 no-op, 01 read, 10 write, 11 no-op |
| addr | input | ADDR_W | Word (beat-pair) address |
| wbeat0 | input | DATA_W | First write beat (low half), cycle after write command |
| wbeat1 | input | DATA_W | Second write beat (high half), cycle after write command |
| lat3 | input | 1 | Latency select: 1 = three cycles, 0 = two |
| rvalid | output | 1 | Read data valid |
| rbeat0 | output | DATA_W | First read beat (low half) |
| rbeat1 | output | DATA_W | Second read beat (high half) |

## Verification
The bench builds the core with 18-bit lanes and a 4-bit address. With only sixteen words, random traffic keeps landing reads on addresses written one cycle earlier, so the forwarding path is exercised often and not just in directed cases. The bench also toggles the latency select freely during bursts of reads. That produces the drain-then-switch ordering and back-to-back reads whose latencies differ on either side of an idle gap.

// File: rtl/sram_b2_pkg.sv
package sram_b2_pkg;

  localparam int BEATS = 2;

  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10,
    CMD_RSV = 2'b11
  } cmd_e;

  function automatic logic is_read(input cmd_e c);
    return c == CMD_RD;
  endfunction

  function automatic logic is_write(input cmd_e c);
    return c == CMD_WR;
  endfunction

endpackage

// File: rtl/sram_b2_wgather.sv
module sram_b2_wgather
  import sram_b2_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 6,
  localparam int WORD_W = BEATS * DATA_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_cmd,
  input  logic [ADDR_W-1:0]            cmd_addr,
  input  logic [BEATS-1:0][DATA_W-1:0] beats,
  output logic                         wr_en,
  output logic [ADDR_W-1:0]            wr_addr,
  output logic [WORD_W-1:0]            wr_word
);

  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;

  // A write command opens a one-cycle window in which its beats arrive.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
    end else begin
      pend_q <= wr_cmd;
      if (wr_cmd) pend_addr_q <= cmd_addr;
    end
  end

  // Demultiplex the beat lanes into one wide storage word, lane 0 lowest.
  for (genvar g = 0; g < BEATS; g++) begin : g_lane
    assign wr_word[g*DATA_W +: DATA_W] = beats[g];
  end

  assign wr_en   = pend_q;
  assign wr_addr = pend_addr_q;

  // R2: an array write only ever happens on the cycle after a write command.
  p_write_follows_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(wr_cmd));

endmodule

// File: rtl/sram_b2_array.sv
module sram_b2_array #(
  parameter int WORD_W = 36,
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic              hit;

  // A read that collides with the write now landing takes the incoming word.
  assign hit = we && (waddr == raddr);

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= hit ? wdata : mem[raddr];
  end

  // R2: a word written one cycle is what a later read of that address sees.
  p_array_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (re && !we && $past(we) && (raddr == $past(waddr)))
      |=> (rdata == $past(wdata, 2)));

endmodule

// File: rtl/sram_b2_rdpipe.sv
module sram_b2_rdpipe
  import sram_b2_pkg::*;
#(
  parameter int DATA_W = 18,
  localparam int WORD_W = BEATS * DATA_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_issue,
  input  logic                         lat3_in,
  input  logic [WORD_W-1:0]            word_in,
  output logic                         lat_eff,
  output logic                         out_v,
  output logic [BEATS-1:0][DATA_W-1:0] out_beats
);

  logic              s1_v, s2_v, lat_q, idle;
  logic [WORD_W-1:0] s2_d, out_d;
  logic              short_done;

  // The array read register is stage 1; stage 2 exists only for three cycles.
  assign idle       = !s1_v && !s2_v;
  assign lat_eff    = idle ? lat3_in : lat_q;
  assign short_done = s1_v && !lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s2_v  <= 1'b0;
      lat_q <= 1'b0;
      s2_d  <= '0;
      out_v <= 1'b0;
      out_d <= '0;
    end else begin
      s1_v  <= rd_issue;
      lat_q <= lat_eff;
      s2_v  <= s1_v && lat_q;
      s2_d  <= (s1_v && lat_q) ? word_in : '0;
      out_v <= short_done || s2_v;
      if (s2_v)            out_d <= s2_d;
      else if (short_done) out_d <= word_in;
      else                 out_d <= '0;
    end
  end

  // Multiplex the wide word onto the beat lanes, low half first.
  for (genvar g = 0; g < BEATS; g++) begin : g_out
    assign out_beats[g] = out_d[g*DATA_W +: DATA_W];
  end

  // R8: the latency in force cannot change while a read is in flight.
  p_lat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v || s2_v) |=> $stable(lat_q));

  // R6: the short and long paths never deliver in the same cycle.
  p_single_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(short_done && s2_v));

  // R10: the lanes are zero whenever no read is being delivered.
  p_zero_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_v |-> (out_d == '0));

endmodule

// File: rtl/sram_b2_core.sv
module sram_b2_core
  import sram_b2_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wbeat0,
  input  logic [DATA_W-1:0] wbeat1,
  input  logic              lat3,
  output logic              rvalid,
  output logic [DATA_W-1:0] rbeat0,
  output logic [DATA_W-1:0] rbeat1
);

  localparam int WORD_W = BEATS * DATA_W;

  cmd_e                         cmd_c;
  logic                         rd_cmd, wr_cmd;
  logic [BEATS-1:0][DATA_W-1:0] win, rout;
  logic                         we;
  logic [ADDR_W-1:0]            waddr;
  logic [WORD_W-1:0]            wword, rword;
  logic                         lat_eff;

  assign cmd_c  = cmd_e'(cmd);
  assign rd_cmd = is_read(cmd_c);
  assign wr_cmd = is_write(cmd_c);
  assign win    = {wbeat1, wbeat0};

  sram_b2_wgather #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_gather (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .cmd_addr(addr),
    .beats(win), .wr_en(we), .wr_addr(waddr), .wr_word(wword)
  );

  sram_b2_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wword),
    .re(rd_cmd), .raddr(addr), .rdata(rword)
  );

  sram_b2_rdpipe #(.DATA_W(DATA_W)) u_rdpipe (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_cmd), .lat3_in(lat3),
    .word_in(rword), .lat_eff(lat_eff), .out_v(rvalid), .out_beats(rout)
  );

  assign rbeat0 = rout[0];
  assign rbeat1 = rout[1];

  // R4: a read issued with an effective latency of two delivers two cycles later.
  p_lat_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && !lat_eff) |-> ##2 rvalid);

  // R5: a read issued with an effective latency of three delivers three cycles later.
  p_lat_three_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd && lat_eff) |-> ##3 rvalid);

  // R6: valid data always traces back to a read two or three cycles earlier.
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> ($past(rd_cmd, 2) || $past(rd_cmd, 3)));

endmodule

// File: tb/sram_b2_core_test.sv
module sram_b2_core_test;

  localparam int DW = 18;
  localparam int AW = 4;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cmd = 2'b00;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wbeat0 = '0, wbeat1 = '0;
  logic          lat3 = 1'b0;
  logic          rvalid;
  logic [DW-1:0] rbeat0, rbeat1;

  always #2 clk = ~clk;  // 250 MHz

  sram_b2_core #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr), .wbeat0(wbeat0),
    .wbeat1(wbeat1), .lat3(lat3), .rvalid(rvalid), .rbeat0(rbeat0), .rbeat1(rbeat1)
  );

  typedef struct {
    logic [DW-1:0] b0;
    logic [DW-1:0] b1;
    int            due;
    string         tag;
  } exp_t;

  exp_t          sbq[$];
  logic [DW-1:0] mlo[NW];
  logic [DW-1:0] mhi[NW];
  int            cyc = 0, nchk = 0, nfail = 0, last_due = 0;
  logic          cur_l3 = 1'b0, pend = 1'b0, run = 1'b0, done = 1'b0;
  logic [DW-1:0] pd0, pd1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  // Driver: one command per cycle; the scoreboard is fed in command order.
  task automatic step(input logic [1:0] c, input int a, input logic [DW-1:0] d0,
                      input logic [DW-1:0] d1, input logic l3, input string tag);
    logic eff;
    exp_t e;
    @(negedge clk);
    cmd  = c;
    addr = AW'(a);
    lat3 = l3;
    if (pend) begin wbeat0 = pd0; wbeat1 = pd1; pend = 1'b0; end
    else begin wbeat0 = DW'($urandom); wbeat1 = DW'($urandom); end
    eff    = (last_due <= cyc) ? l3 : cur_l3;
    cur_l3 = eff;
    if (c == 2'b10) begin
      mlo[a] = d0; mhi[a] = d1; pend = 1'b1; pd0 = d0; pd1 = d1;
    end
    if (c == 2'b01) begin
      e.b0 = mlo[a]; e.b1 = mhi[a]; e.due = cyc + (eff ? 3 : 2); e.tag = tag;
      last_due = e.due;
      sbq.push_back(e);
    end
  endtask

  task automatic idle(input int n, input logic l3);
    for (int i = 0; i < n; i++) step(2'b00, 0, '0, '0, l3, "");
  endtask

  // Monitor: pops the scoreboard whenever the design delivers data.
  always @(negedge clk) begin
    if (run) begin
      if (rvalid) begin
        nchk++;
        if (sbq.size() == 0) begin
          nfail++;
          $display("FAIL R6 spurious rvalid at cycle %0d: actual 1 expected 0", cyc);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          if (e.due != cyc) begin
            nfail++;
            $display("FAIL R4/R5 timing: actual cycle %0d expected %0d", cyc, e.due);
          end
          nchk++;
          if (rbeat0 !== e.b0 || rbeat1 !== e.b1) begin
            nfail++;
            $display("FAIL %s read data: actual %h/%h expected %h/%h",
                     e.tag, rbeat0, rbeat1, e.b0, e.b1);
          end
        end
      end else begin
        nchk++;
        if (rbeat0 !== '0 || rbeat1 !== '0) begin
          nfail++;
          $display("FAIL R10 idle lanes: actual %h/%h expected 0/0", rbeat0, rbeat1);
        end
        if (sbq.size() > 0 && sbq[0].due <= cyc) begin
          nfail++;
          $display("FAIL R6 missing rvalid: actual 0 expected 1 at cycle %0d", sbq[0].due);
          void'(sbq.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired: actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    nchk++;
    if (rvalid !== 1'b0 || rbeat0 !== '0 || rbeat1 !== '0) begin
      nfail++;
      $display("FAIL R1 in reset: actual %b %h/%h expected 0 0/0", rvalid, rbeat0, rbeat1);
    end
    rst_n = 1'b1;
    @(negedge clk);
    nchk++;
    if (rvalid !== 1'b0 || rbeat0 !== '0 || rbeat1 !== '0) begin
      nfail++;
      $display("FAIL R1 after reset: actual %b %h/%h expected 0 0/0", rvalid, rbeat0, rbeat1);
    end
    run = 1'b1;

    // Fill every word; R2 packs beat 0 low and beat 1 high.
    for (int a = 0; a < NW; a++) step(2'b10, a, DW'(a * 3 + 1), DW'(a * 5 + 2), 1'b0, "");
    idle(2, 1'b0);

    step(2'b01, 3, '0, '0, 1'b0, "R2/R3");   // two-cycle read
    idle(4, 1'b0);
    step(2'b01, 5, '0, '0, 1'b1, "R5");      // three-cycle read
    idle(5, 1'b1);
    step(2'b01, 6, '0, '0, 1'b0, "R4");
    idle(4, 1'b0);

    // R6: back-to-back reads at both latencies.
    for (int a = 0; a < 8; a++) step(2'b01, a, '0, '0, 1'b0, "R6");
    idle(4, 1'b1);
    for (int a = 8; a < 16; a++) step(2'b01, a, '0, '0, 1'b1, "R6");
    idle(5, 1'b1);

    // R7: a read right after a write to the same word gets the new data.
    step(2'b10, 9, 18'h2aaaa, 18'h15555, 1'b0, "");
    step(2'b01, 9, '0, '0, 1'b0, "R7");
    step(2'b10, 9, 18'h01234, 18'h3fedc, 1'b0, "");
    step(2'b00, 0, '0, '0, 1'b0, "");
    step(2'b01, 9, '0, '0, 1'b0, "R7");
    idle(4, 1'b1);
    step(2'b10, 10, 18'h0beef, 18'h0cafe, 1'b1, "");
    step(2'b01, 10, '0, '0, 1'b1, "R7");
    idle(5, 1'b0);

    // R8: the select flips mid-burst and only applies after the drain.
    step(2'b01, 1, '0, '0, 1'b0, "R8");
    step(2'b01, 2, '0, '0, 1'b1, "R8");
    step(2'b01, 4, '0, '0, 1'b1, "R8");
    idle(4, 1'b1);
    step(2'b01, 7, '0, '0, 1'b1, "R8");
    step(2'b01, 8, '0, '0, 1'b0, "R8");
    idle(5, 1'b0);

    // R9: reserved and no-op commands with junk beats leave words untouched.
    step(2'b11, 4, '0, '0, 1'b0, "");
    step(2'b00, 4, '0, '0, 1'b0, "");
    step(2'b11, 11, '0, '0, 1'b0, "");
    step(2'b01, 4, '0, '0, 1'b0, "R9");
    step(2'b01, 11, '0, '0, 1'b0, "R9");
    idle(4, 1'b0);

    // Mixed random traffic on a small address space.
    for (int i = 0; i < 600; i++) begin
      int  r;
      logic l3r;
      r   = int'($urandom % 4);
      l3r = ($urandom % 8) < 3;
      step(2'(r), int'($urandom % NW), DW'($urandom), DW'($urandom), l3r, "R3/R7");
    end
    idle(8, 1'b0);

    nchk++;
    if (sbq.size() != 0) begin
      nfail++;
      $display("FAIL R6 undelivered reads: actual %0d expected 0", sbq.size());
    end
    done = 1'b1;
    summary();
  end

endmodule